// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address presented to a synchronous burst memory. A start address is captured on a rising clock edge whenever either of two load strobes is high. One strobe serves a processor and the other serves a cache controller. After that first access, the block forms the following addresses from a small wrap counter that steps only on cycles with the advance input high. The upper address bits stay at the captured value. Only the low bits move through the burst.

A mode input picks the burst order. With the mode low, the low bits climb linearly modulo four from the start value. With the mode high, the low bits are the start value XORed with the count. A board that leaves the pin unconnected should pull it high, which gives the interleaved order. A second output reports how many advances have happened since the last load. A synchronous reset clears both the held address and the count.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `addrOut` is 0 and `burstCount` is 0. Reset takes priority over every other input.
- R2: When `procLoad` is high at a rising edge, after that edge `addrOut` equals the sampled `addrIn` and `burstCount` is 0.
- R3: When `cacheLoad` is high at a rising edge, after that edge `addrOut` equals the sampled `addrIn` and `burstCount` is 0.
- R4: With `modeSel` = 0 (linear order), `addrOut[1:0]` equals (start low bits + `burstCount`) modulo 4. A start of 2 gives 2, 3, 0, 1.
- R5: With `modeSel` = 1 (interleaved order), `addrOut[1:0]` equals the start low bits XOR `burstCount`. A start of 1 gives 1, 0, 3, 2.
- R6: When `advance` is high at an edge and neither load strobe is high, `burstCount` increments modulo 4. After four advances, `addrOut` is back at the start address.
- R7: When `advance` and both load strobes are low at an edge, `addrOut` and `burstCount` keep their values.
- R8: When a load strobe and `advance` are high at the same edge, the load wins: the new address is taken and `burstCount` becomes 0.
- R9: Between loads, the bits of `addrOut` above bit 1 never change. No carry leaves the low two bits, even when the start address has all upper bits set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | ADDR_W | External start address |
| procLoad | input | 1 | Load strobe from the processor side |
| cacheLoad | input | 1 | Load strobe from the cache-controller side |
| advance | input | 1 | Step the burst counter |
| modeSel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addrOut | output | ADDR_W | Current word address |
| burstCount | output | CNT_W | Advances since the last load |

## Verification
Several properties are checked on every cycle by the assertions:
- the result after any load, including a load that collides with an advance;
- the counter step and the hold;
- that the upper address bits stay fixed between loads;
- how the low bits relate from one step to the next in each order.

Some behaviour only the bench scenarios can show:
- that a full burst from a given start visits the exact listed sequence;
- that it returns to its start after four steps;
- that the two strobes are interchangeable;
- that an all-ones upper field produces no carry.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef struct packed {
    logic clearEn;
    logic loadEn;
    logic stepEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic         rst,
  input  logic         procLoad,
  input  logic         cacheLoad,
  input  logic         advance,
  output ctrlStrobes_t strobes
);
  logic anyLoad;

  assign anyLoad = procLoad | cacheLoad;

  always_comb begin
    strobes.clearEn = rst;
    strobes.loadEn  = !rst && anyLoad;
    strobes.stepEn  = !rst && !anyLoad && advance;
  end
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              modeSel,
  output logic [ADDR_W-1:0] addrOut,
  output logic [CNT_W-1:0]  burstCount
);
  localparam int UPPER_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  startLow;
  logic [CNT_W-1:0]  linearLow;
  logic [CNT_W-1:0]  interLow;
  logic [CNT_W-1:0]  orderedLow;

  always_ff @(posedge clk) begin
    if (strobes.clearEn) begin
      baseAddr <= '0;
      cntQ     <= '0;
    end else if (strobes.loadEn) begin
      baseAddr <= addrIn;
      cntQ     <= '0;
    end else if (strobes.stepEn) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign startLow  = baseAddr[CNT_W-1:0];
  assign linearLow = startLow + cntQ;
  assign interLow  = startLow ^ cntQ;

  always_comb begin
    orderedLow = modeSel ? interLow : linearLow;
  end

  generate
    if (UPPER_W > 0) begin : g_upper
      assign addrOut = {baseAddr[ADDR_W-1:CNT_W], orderedLow};
    end else begin : g_noUpper
      assign addrOut = orderedLow;
    end
  endgenerate

  assign burstCount = cntQ;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procLoad,
  input  logic              cacheLoad,
  input  logic              advance,
  input  logic              modeSel,
  output logic [ADDR_W-1:0] addrOut,
  output logic [CNT_W-1:0]  burstCount
);
  ctrlStrobes_t strobes;

  burst_ctrl u_ctrl (
    .rst       (rst),
    .procLoad  (procLoad),
    .cacheLoad (cacheLoad),
    .advance   (advance),
    .strobes   (strobes)
  );

  burst_datapath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk        (clk),
    .strobes    (strobes),
    .addrIn     (addrIn),
    .modeSel    (modeSel),
    .addrOut    (addrOut),
    .burstCount (burstCount)
  );
endmodule

// File: rtl/burst_addr_gen_checker.sv
module burst_addr_gen_checker #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addrIn,
  input logic              procLoad,
  input logic              cacheLoad,
  input logic              advance,
  input logic              modeSel,
  input logic [ADDR_W-1:0] addrOut,
  input logic [CNT_W-1:0]  burstCount
);
  logic anyLoad;
  assign anyLoad = procLoad | cacheLoad;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (addrOut == '0) && (burstCount == '0));

  // R2, R3, R8
  a_r2_r3_r8_load: assert property (@(posedge clk) disable iff (rst)
    anyLoad |=> (burstCount == '0) &&
                (addrOut[ADDR_W-1:CNT_W] == $past(addrIn[ADDR_W-1:CNT_W])));

  // R6
  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    (!anyLoad && advance) |=> burstCount == CNT_W'($past(burstCount) + 1'b1));

  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!anyLoad && !advance) |=> $stable(burstCount) && $stable(addrOut[ADDR_W-1:CNT_W]));

  // R9
  a_r9_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    !anyLoad |=> $stable(addrOut[ADDR_W-1:CNT_W]));

  // R4
  a_r4_linear_step: assert property (@(posedge clk) disable iff (rst)
    (!anyLoad && advance && !modeSel) |=>
      (modeSel || addrOut[CNT_W-1:0] == CNT_W'($past(addrOut[CNT_W-1:0]) + 1'b1)));

  // R5
  a_r5_inter_step: assert property (@(posedge clk) disable iff (rst)
    (!anyLoad && advance && modeSel) |=>
      (!modeSel || (addrOut[CNT_W-1:0] ^ $past(addrOut[CNT_W-1:0])) ==
                   (burstCount ^ $past(burstCount))));
endmodule

bind burst_addr_gen burst_addr_gen_checker #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addrIn     (addrIn),
  .procLoad   (procLoad),
  .cacheLoad  (cacheLoad),
  .advance    (advance),
  .modeSel    (modeSel),
  .addrOut    (addrOut),
  .burstCount (burstCount)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int CNT_W  = 2;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;
    string             tag;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              procLoad = 1'b0;
  logic              cacheLoad = 1'b0;
  logic              advance = 1'b0;
  logic              modeSel = 1'b1;
  logic [ADDR_W-1:0] addrOut;
  logic [CNT_W-1:0]  burstCount;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  expItem_t expQ[$];

  logic [ADDR_W-1:0] mBase = '0;
  logic [CNT_W-1:0]  mCnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .addrIn(addrIn), .procLoad(procLoad),
    .cacheLoad(cacheLoad), .advance(advance), .modeSel(modeSel),
    .addrOut(addrOut), .burstCount(burstCount)
  );

  function automatic logic [ADDR_W-1:0] modelAddr(input logic m);
    logic [1:0] lo;
    lo = m ? (mBase[1:0] ^ mCnt) : (mBase[1:0] + mCnt);
    return {mBase[ADDR_W-1:2], lo};
  endfunction

  // Driver: drives inputs just after a falling edge and pushes the expected result.
  task automatic drive(input logic r, input logic p, input logic c, input logic a,
                       input logic m, input logic [ADDR_W-1:0] ad, input string tag);
    expItem_t it;
    @(negedge clk);
    #2;
    rst = r; procLoad = p; cacheLoad = c; advance = a; modeSel = m; addrIn = ad;
    @(posedge clk);
    if (r) begin
      mBase = '0; mCnt = '0;
    end else if (p || c) begin
      mBase = ad; mCnt = '0;
    end else if (a) begin
      mCnt = mCnt + 1'b1;
    end
    #1;
    it.addr = modelAddr(m);
    it.cnt  = mCnt;
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compares on the falling edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (addrOut !== it.addr || burstCount !== it.cnt) begin
        errors++;
        $display("FAIL %s: addr=%h cnt=%0d expected addr=%h cnt=%0d",
                 it.tag, addrOut, burstCount, it.addr, it.cnt);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset, with a load strobe held high alongside it
    drive(1, 1, 0, 1, 1, 20'hABCDE, "R1");
    drive(1, 0, 0, 0, 1, '0, "R1");
    // R2 then R4 linear from start 2
    drive(0, 1, 0, 0, 0, 20'h12342, "R2");
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 1, 0, '0, "R4/R6");
    // R3 then R5 interleaved from start 1
    drive(0, 0, 1, 0, 1, 20'h56781, "R3");
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 1, 1, '0, "R5/R6");
    // R7 hold
    drive(0, 0, 0, 1, 1, '0, "R6");
    drive(0, 0, 0, 0, 1, '0, "R7");
    drive(0, 0, 0, 0, 1, '0, "R7");
    // R8 load wins over advance
    drive(0, 1, 0, 1, 1, 20'h0AAA3, "R8");
    drive(0, 0, 1, 1, 0, 20'h0BBB2, "R8");
    // R9 upper all ones, linear from 3 must not carry
    drive(0, 1, 0, 0, 0, 20'hFFFFF, "R2");
    for (int i = 0; i < 5; i++) drive(0, 0, 0, 1, 0, '0, "R9");
    // R9 interleaved
    drive(0, 0, 1, 0, 1, 20'hFFFFE, "R3");
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 1, 1, '0, "R9");
    // R1 reset mid-burst
    drive(1, 0, 0, 1, 0, '0, "R1");
    drive(0, 0, 0, 0, 1, '0, "R1");
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule